// File: doc/BRIEF.md
# Two-Wire Management Bus Configuration Register Slave

This block lets a host reach a small bank of 8-bit configuration registers over a two-wire management bus. It watches the clock (SCL) and data (SDA) lines through synchronising flops, finds start and stop conditions, and compares the 7-bit address with its own. On a match it acknowledges and then takes a command byte. The command byte selects either one register or a run of registers, starting at a given offset. The block drives SDA only by pulling it low, through an open-drain enable output. The current register contents appear on a flat output vector for the logic nearby to use.

There are two kinds of access, and both directions support each. A byte access touches one register. A block access has a byte count: in a write it comes from the host, and in a read the slave sends it first. The data bytes then follow, and the register offset goes up by one after each byte. The low bits of register 0 hold strap inputs, captured while reset is asserted, and the bus cannot change them.

Top module: `smb_cfg_slave`

## Requirements
- R1: While reset is low and after it is released, `sda_oe` is 0. Registers 1 to NREG-1 read 0x00, and register 0 reads 0x00 outside its strap bits.
- R2: The first byte after a start holds the 7-bit address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). If the address equals SLV_ADDR (default 0x69), the slave acknowledges that byte. Otherwise it leaves SDA released and ignores everything, with no acknowledges and no writes, until the next start.
- R3: In a write, the byte after the address is a command. If command bit 7 is 1, the access is a byte access; if it is 0, the access is a block access. Bits 6:0 set the register offset in both cases.
- R4: In a byte write, the slave writes the first data byte to the register at the offset and acknowledges it. It does not acknowledge any further data byte and does not write it.
- R5: A byte read is a write of the address and a byte command, then a repeated start and the read address. The slave returns the register at the command offset.
- R6: In a block write, the first byte after the command is a count N. The slave writes the next N bytes to consecutive offsets, starting at the command offset. A byte beyond N gets no acknowledge and is not written.
- R7: In a block read, the slave first sends a count equal to NREG minus the offset, or 0 if the offset is NREG or above. It then sends the registers from the offset upward.
- R8: When the host answers a read byte with a not-acknowledge, the slave releases SDA and drives nothing more in that transfer.
- R9: Register 0 bits STRAP_W-1:0 (default 4:0) take `strap_in` while reset is low. Bus writes leave those bits unchanged but do update the other bits.
- R10: Offsets of NREG and above are acknowledged on write but store nothing, and they read as 0x00.
- R11: `sda_oe` rises only while SCL is low.
- R12: A falling SDA while SCL is high is a start, and it restarts address reception even in the middle of a byte. A rising SDA while SCL is high is a stop. Both leave SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_in | input | STRAP_W | Strap levels captured into register 0 during reset |
| cfg_out | output | NREG*8 | All registers, register k in bits 8k+7:8k |

## Verification
The bench targets the edges of each access: the byte after the single allowed byte write, the byte after the block count runs out, and the host's not-acknowledge that ends a read. A design that got these wrong would write past the end of the transfer or keep driving SDA into the host's stop. It also sends a foreign address followed by data, writes to an offset above the bank, and writes all ones to the strap register. A faulty design would acknowledge the foreign address, overwrite a register through a wrapped offset, or lose the strap levels. Finally, a start cut into the middle of an address byte checks that a design which kept its old bit count would fail to acknowledge the restarted address.

// File: rtl/smb_pkg.sv
// Shared types for the management-bus register slave.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package smb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, waiting for a start
        ST_RX,     // shifting in a byte from the host
        ST_RXACK,  // acknowledge slot for a received byte
        ST_TX,     // shifting out a byte to the host
        ST_TXACK   // host acknowledge slot for a sent byte
    } bus_st_t;

    typedef enum logic [1:0] {
        PH_ADDR,   // address plus direction byte
        PH_CMD,    // command byte
        PH_CNT,    // block write count byte
        PH_DATA    // data bytes
    } rx_ph_t;
endpackage

// File: rtl/smb_line_sync.sv
// Synchronises SCL/SDA and derives clock edges and start/stop events.
// Assumes: bus lines idle high; SDA changes well away from SCL edges.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // One stage beyond the synchroniser keeps the previous sample.
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;

    // Shift both lines through the synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_in};
        end
    end

    // Edge and condition decode from current versus previous samples.
    always_comb begin
        scl_q     = scl_pipe[SYNC_STAGES-1];
        sda_q     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_q & ~scl_pipe[SYNC_STAGES];
        scl_fall  = ~scl_q & scl_pipe[SYNC_STAGES];
        start_det = scl_q & scl_pipe[SYNC_STAGES] & sda_pipe[SYNC_STAGES] & ~sda_q;
        stop_det  = scl_q & scl_pipe[SYNC_STAGES] & ~sda_pipe[SYNC_STAGES] & sda_q;
    end
endmodule

// File: rtl/smb_cfg_bank.sv
// Configuration register bank with strap-loaded read-only bits in register 0.
// Assumes: offsets at or above NREG are ignored on write and read as zero.
module smb_cfg_bank #(
    parameter int NREG    = 8,
    parameter int OFS_W   = 7,
    parameter int STRAP_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STRAP_W-1:0]  strap_in,
    input  logic                wr_en,
    input  logic [OFS_W-1:0]    wr_ofs,
    input  logic [7:0]          wr_data,
    input  logic [OFS_W-1:0]    rd_ofs,
    output logic [7:0]          rd_data,
    output logic [NREG*8-1:0]   cfg_flat
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [7:0] STRAP_MASK = 8'((1 << STRAP_W) - 1);

    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] RO_M = (g == 0) ? STRAP_MASK : 8'h00;
        logic [7:0] q;
        // Hold one register; read-only bits keep their strap value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= (g == 0) ? 8'(strap_in) : 8'h00;
            else if (wr_en && (int'(wr_ofs) == g))
                q <= (wr_data & ~RO_M) | (q & RO_M);
        end
        assign regs[g] = q;
        assign cfg_flat[g*8 +: 8] = q;
    end

    // Read mux with zero beyond the bank.
    always_comb begin
        if (int'(rd_ofs) < NREG)
            rd_data = regs[rd_ofs[IDX_W-1:0]];
        else
            rd_data = 8'h00;
    end
endmodule

// File: rtl/smb_proto_fsm.sv
// Bus protocol engine: address match, command decode, byte/block transfers.
// Assumes: edges and start/stop come from smb_line_sync; SDA is open drain.
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR = 7'h69,
    parameter int         NREG     = 8,
    parameter int         OFS_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_q,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [OFS_W-1:0] rd_ofs,
    output logic             wr_en,
    output logic [OFS_W-1:0] wr_ofs,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    bus_st_t          state;
    rx_ph_t           phase, next_phase;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [OFS_W-1:0] ptr;
    logic [7:0]       remain;
    logic             blk_mode;
    logic             rd_dir;
    logic             cnt_pending;
    logic [7:0]       blk_count;
    logic [7:0]       tx_byte;

    assign rd_ofs = ptr;

    // Block count, next byte to send and next receive phase.
    always_comb begin
        blk_count = (int'(ptr) < NREG) ? 8'(NREG - int'(ptr)) : 8'h00;
        tx_byte   = cnt_pending ? blk_count : rd_data;
        case (phase)
            PH_ADDR: next_phase = PH_CMD;
            PH_CMD:  next_phase = blk_mode ? PH_CNT : PH_DATA;
            default: next_phase = PH_DATA;
        endcase
    end

    // Protocol sequencing; start and stop override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= PH_ADDR;
            bitcnt      <= '0;
            shreg       <= '0;
            ptr         <= '0;
            remain      <= '0;
            blk_mode    <= 1'b0;
            rd_dir      <= 1'b0;
            cnt_pending <= 1'b0;
            wr_en       <= 1'b0;
            wr_ofs      <= '0;
            wr_data     <= '0;
            sda_oe      <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_RX;
                phase  <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                blk_mode <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_q};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            state  <= ST_RXACK;
                            sda_oe <= 1'b1;
                            case (phase)
                                PH_ADDR: begin
                                    if (shreg[7:1] != SLV_ADDR) begin
                                        state  <= ST_IDLE;
                                        sda_oe <= 1'b0;
                                    end else begin
                                        rd_dir      <= shreg[0];
                                        cnt_pending <= shreg[0] & blk_mode;
                                    end
                                end
                                PH_CMD: begin
                                    ptr      <= shreg[OFS_W-1:0];
                                    blk_mode <= ~shreg[7];
                                    remain   <= shreg[7] ? 8'd1 : 8'd0;
                                end
                                PH_CNT: remain <= shreg;
                                default: begin
                                    if (remain != 8'd0) begin
                                        wr_en   <= 1'b1;
                                        wr_ofs  <= ptr;
                                        wr_data <= shreg;
                                        ptr     <= ptr + 1'b1;
                                        remain  <= remain - 8'd1;
                                    end else begin
                                        state  <= ST_IDLE;
                                        sda_oe <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RXACK: begin
                        if (scl_fall) begin
                            if (phase == PH_ADDR && rd_dir) begin
                                state  <= ST_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                bitcnt <= 4'd1;
                                if (cnt_pending) cnt_pending <= 1'b0;
                                else             ptr <= ptr + 1'b1;
                            end else begin
                                state  <= ST_RX;
                                phase  <= next_phase;
                                bitcnt <= '0;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                state  <= ST_TXACK;
                                sda_oe <= 1'b0;
                            end else begin
                                sda_oe <= ~shreg[6];
                                shreg  <= {shreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise && sda_q) begin
                            state <= ST_IDLE;
                        end else if (scl_fall) begin
                            state  <= ST_TX;
                            shreg  <= tx_byte;
                            sda_oe <= ~tx_byte[7];
                            bitcnt <= 4'd1;
                            if (cnt_pending) cnt_pending <= 1'b0;
                            else             ptr <= ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_cfg_slave.sv
// Top: management-bus slave giving byte and block access to a register bank.
// Assumes: system clock oversamples SCL by at least 8x; SDA pad is open drain.
module smb_cfg_slave #(
    parameter logic [6:0] SLV_ADDR    = 7'h69,
    parameter int         NREG        = 8,
    parameter int         STRAP_W     = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_oe,
    input  logic [STRAP_W-1:0]  strap_in,
    output logic [NREG*8-1:0]   cfg_out
);
    localparam int OFS_W = 7;

    logic             scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [OFS_W-1:0] wr_ofs, rd_ofs;
    logic [7:0]       wr_data, rd_data;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_proto_fsm #(.SLV_ADDR(SLV_ADDR), .NREG(NREG), .OFS_W(OFS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .rd_ofs(rd_ofs), .wr_en(wr_en), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    smb_cfg_bank #(.NREG(NREG), .OFS_W(OFS_W), .STRAP_W(STRAP_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .wr_en(wr_en),
        .wr_ofs(wr_ofs), .wr_data(wr_data), .rd_ofs(rd_ofs), .rd_data(rd_data),
        .cfg_flat(cfg_out)
    );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
// Protocol checker for smb_cfg_slave, attached by bind.
// Assumes: reset is asserted from time zero.
module smb_cfg_slave_chk #(
    parameter int NREG    = 8,
    parameter int STRAP_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_q,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_out
);
    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q); // R11
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R12
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe); // R12
    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe); // R4
    AST_STRAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_out[STRAP_W-1:0])); // R9
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .STRAP_W(STRAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_det(start_det),
    .stop_det(stop_det), .wr_en(wr_en), .sda_oe(sda_oe), .cfg_out(cfg_out)
);

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
// Directed bench: a bit-level bus master runs one task per scenario.
module tb_smb_cfg_slave;
    localparam int NREG = 8;
    localparam int STRAP_W = 5;
    localparam int Q = 10;               // quarter SCL period in clocks
    localparam logic [7:0] AW = 8'hD2;   // address 0x69, write
    localparam logic [7:0] AR = 8'hD3;   // address 0x69, read
    localparam logic [7:0] STRAP = 8'h16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [STRAP_W-1:0] strap = STRAP[STRAP_W-1:0];
    logic [NREG*8-1:0] cfg_out;
    int nchk = 0;
    int nerr = 0;
    int viol = 0;
    logic oe_seen = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    smb_cfg_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .strap_in(strap), .cfg_out(cfg_out)
    );

    // R11 monitor: any SDA pull-down change seen while SCL is high.
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== oe_seen) && m_scl && sda_oe) viol <= viol + 1;
        oe_seen <= sda_oe;
    end

    function automatic logic [7:0] cfg(input int i);
        return cfg_out[i*8 +: 8];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wait_clk(Q); m_scl = 1'b1; wait_clk(2*Q); m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wait_clk(Q); m_scl = 1'b1; wait_clk(Q); b = sda_line;
        wait_clk(Q); m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(Q); m_scl = 1'b1; wait_clk(Q);
        m_sda = 1'b0; wait_clk(Q); m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(Q); m_scl = 1'b1; wait_clk(Q); m_sda = 1'b1; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic wr_byte(input logic [7:0] ofs, input logic [7:0] d, output logic ack);
        logic a0, a1;
        bus_start(); send_byte(AW, a0); send_byte({1'b1, ofs[6:0]}, a1); send_byte(d, ack);
        bus_stop();
        ack = ack & a0 & a1;
    endtask

    task automatic rd_byte(input logic [7:0] ofs, output logic [7:0] d);
        logic a;
        bus_start(); send_byte(AW, a); send_byte({1'b1, ofs[6:0]}, a);
        bus_start(); send_byte(AR, a); recv_byte(1'b0, d); bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 sda released", {63'd0, sda_oe}, 64'd0);
        chk("R1/R9 reg0 strap", {56'd0, cfg(0)}, {56'd0, STRAP});
        for (int i = 1; i < NREG; i++) chk("R1 reg clear", {56'd0, cfg(i)}, 64'd0);
    endtask

    task automatic t_byte_write();
        logic a;
        bus_start();
        send_byte(AW, a);   chk("R2 address ack", {63'd0, a}, 64'd1);
        send_byte(8'h83, a); chk("R3 byte command ack", {63'd0, a}, 64'd1);
        send_byte(8'hA5, a); chk("R4 data ack", {63'd0, a}, 64'd1);
        send_byte(8'h77, a); chk("R4 extra byte nack", {63'd0, a}, 64'd0);
        bus_stop();
        chk("R4 reg3 written", {56'd0, cfg(3)}, 64'hA5);
        chk("R4 reg4 untouched", {56'd0, cfg(4)}, 64'h00);
    endtask

    task automatic t_byte_read();
        logic a;
        logic [7:0] d;
        bus_start(); send_byte(AW, a); send_byte(8'h83, a);
        bus_start(); send_byte(AR, a); chk("R2 read address ack", {63'd0, a}, 64'd1);
        recv_byte(1'b0, d); chk("R5 byte read data", {56'd0, d}, 64'hA5);
        chk("R8 released after nack", {63'd0, sda_oe}, 64'd0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte(8'h44, a); chk("R2 foreign address nack", {63'd0, a}, 64'd0);
        send_byte(8'h81, a); chk("R2 ignored command", {63'd0, a}, 64'd0);
        send_byte(8'hEE, a); chk("R2 ignored data", {63'd0, a}, 64'd0);
        bus_stop();
        chk("R2 reg1 unchanged", {56'd0, cfg(1)}, 64'h00);
    endtask

    task automatic t_block_write();
        logic a;
        bus_start(); send_byte(AW, a); send_byte(8'h02, a);
        chk("R3 block command ack", {63'd0, a}, 64'd1);
        send_byte(8'h03, a); chk("R6 count ack", {63'd0, a}, 64'd1);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        chk("R6 last counted ack", {63'd0, a}, 64'd1);
        send_byte(8'h44, a); chk("R6 beyond count nack", {63'd0, a}, 64'd0);
        bus_stop();
        chk("R6 reg2", {56'd0, cfg(2)}, 64'h11);
        chk("R6 reg3", {56'd0, cfg(3)}, 64'h22);
        chk("R6 reg4", {56'd0, cfg(4)}, 64'h33);
        chk("R6 reg5 untouched", {56'd0, cfg(5)}, 64'h00);
    endtask

    task automatic t_block_read();
        logic a, b;
        logic [7:0] d;
        logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00};
        bus_start(); send_byte(AW, a); send_byte(8'h02, a);
        bus_start(); send_byte(AR, a);
        recv_byte(1'b1, d); chk("R7 block count", {56'd0, d}, 64'd6);
        for (int i = 0; i < 6; i++) begin
            recv_byte(i != 5, d);
            chk("R7 block data", {56'd0, d}, {56'd0, exp[i]});
        end
        get_bit(b); chk("R8 no drive after nack", {63'd0, b}, 64'd1);
        bus_stop();
    endtask

    task automatic t_strap();
        logic a;
        logic [7:0] d;
        wr_byte(8'h00, 8'hFF, a); chk("R9 write ack", {63'd0, a}, 64'd1);
        chk("R9 strap bits kept", {56'd0, cfg(0)}, 64'hF6);
        rd_byte(8'h00, d); chk("R9 readback", {56'd0, d}, 64'hF6);
    endtask

    task automatic t_range();
        logic a;
        logic [7:0] d;
        logic [NREG*8-1:0] snap;
        snap = cfg_out;
        wr_byte(8'h0A, 8'h5A, a); chk("R10 write ack", {63'd0, a}, 64'd1);
        chk("R10 bank unchanged", cfg_out, snap);
        rd_byte(8'h0A, d); chk("R10 read zero", {56'd0, d}, 64'h00);
        bus_start(); send_byte(AW, a); send_byte(8'h09, a);
        bus_start(); send_byte(AR, a);
        recv_byte(1'b0, d); chk("R7 count zero beyond bank", {56'd0, d}, 64'h00);
        bus_stop();
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(AW, a); chk("R12 restart address ack", {63'd0, a}, 64'd1);
        send_byte(8'h81, a); send_byte(8'h3C, a);
        bus_stop();
        chk("R12 write after restart", {56'd0, cfg(1)}, 64'h3C);
    endtask

    task automatic finish_run();
        chk("R11 no pull-down rise with SCL high", 64'(viol), 64'd0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        wait_clk(8);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_byte_write();
        t_byte_read();
        t_mismatch();
        t_block_write();
        t_block_read();
        t_strap();
        t_range();
        t_restart();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R12 watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule